// File: doc/BRIEF.md
# Per-Channel Transfer and Error Status Image

This block keeps a status image for up to 32 communication channels and presents it as one fixed 80-bit vector that a controller reads once per scan. Each channel owns two bits in the image. One is a transfer pulse that reads 1 for exactly one scan after one or more successful transfers in the previous scan period. The other is a sticky error flag. The lowest 16 bits of the image belong to other logic and are driven to 0 here.

Channels are set up and torn down by establish and abort commands, each carrying a channel index. When an establish command is accepted, the block writes a command status word through a valid/ready handshake. The channel stays inactive until that write completes, so neither of its status bits can rise before the word is written. The error flag has several clearing sources: establish, recovery from a transient fault, abort, and a RUN-to-STOP transition of the mode input.

Events and the image are kept separate. Transfer events collect in a per-channel pending flag. The error flag tracks events as they arrive. At each scan strobe both are copied into the image, so the image reports the preceding period and is only loosely tied to when the events actually happened.

Top module: `chan_status_img`

## Requirements
- R1: The image is laid out as follows, with status bit k at `img_o[k-1]`. For channel c (the value on `cmd_chan_i`, 0 to 31), the transfer bit is at `img_o[16+2c]` and the error bit is at `img_o[17+2c]`. `img_o[15:0]` is always 0.
- R2: No image bit changes from 0 to 1 except on a clock edge where `scan_i` is 1.
- R3: Transfer events (`xfer_i[c]`) on an active channel collect between strobes. An event in the same cycle as a strobe counts toward the next period. At the next strobe the transfer bit becomes 1. At the following strobe it returns to 0 unless new events arrived. Several events in one period give a single pulse.
- R4: An error event (`err_det_i[c]`) on an active channel sets a sticky error flag. The image error bit shows the flag at the next strobe and keeps showing it at later strobes until the flag is cleared.
- R5: A recovery event (`err_rcv_i[c]`) clears the error flag. If detect and recovery occur in the same cycle, detect wins and the flag is set.
- R6: An accepted abort (`cmd_est_i`=0) makes the channel inactive and clears its flags. Both of its image bits read 0 on the next cycle. An inactive or never-established channel ignores all events, and a detect in the abort cycle is lost.
- R7: In a cycle where `run_i` has fallen from 1 to 0, every error flag is cleared, and a detect in that same cycle is lost. The image error bits read 0 from the next strobe onward.
- R8: A command is accepted when `cmd_valid_i` and `cmd_ready_o` are both 1. After an accepted establish (`cmd_est_i`=1):
  - On the next cycle `sw_valid_o` is 1, `sw_chan_o` holds the channel and `sw_word_o` holds the success code 16'h0001.
  - These outputs stay unchanged until `sw_ready_i` is 1, and `cmd_ready_o` is 0 for that whole time.
  - Until the write completes, the channel's image bits are 0 and its events are ignored.
- R9: On the cycle the status word write completes, the channel becomes active with its error flag cleared. Events in that same cycle already count.
- R10: A synchronous active-high reset makes every channel inactive. It clears all flags and the image, drops `sw_valid_o` and raises `cmd_ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_i | input | 1 | Scan strobe; copies the collected state into the image |
| xfer_i | input | 32 | Per-channel transfer-complete events |
| err_det_i | input | 32 | Per-channel error-detected events |
| err_rcv_i | input | 32 | Per-channel error-recovered events |
| run_i | input | 1 | Mode: 1 RUN, 0 STOP |
| cmd_valid_i | input | 1 | Command request |
| cmd_est_i | input | 1 | 1 establish, 0 abort |
| cmd_chan_i | input | 5 | Command channel index |
| cmd_ready_o | output | 1 | Command can be accepted |
| sw_valid_o | output | 1 | Status word write request |
| sw_ready_i | input | 1 | Status word write accepted |
| sw_chan_o | output | 5 | Channel of the status word |
| sw_word_o | output | 16 | Status word value |
| img_o | output | 80 | Status image |

## Verification
Errors in the internal pending flag, error flag or activity state show up in the image no later than the next scan strobe, and an abort shows up one cycle after it is accepted. For example, a flag that was not cleared shows as a pulse lasting two scans, or as an error bit that stays 1 after abort, recovery or stop. Another case is a bit on a channel that should be silent. A wrong ordering between the status word and a channel's bits shows as a rising image bit while `sw_valid_o` is still high. The bench uses a stimulus table to cover the pulse and error sequences. It then runs directed cases for ignored events, same-cycle conflicts between events, the handshake window, abort, stop and reset.

// File: rtl/chan_status_img.sv
module chan_status_img #(
  parameter int NCH     = 32,
  parameter int IMG_W   = 80,
  parameter int SW_W    = 16,
  parameter int OK_CODE = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scan_i,
  input  logic [NCH-1:0]           xfer_i,
  input  logic [NCH-1:0]           err_det_i,
  input  logic [NCH-1:0]           err_rcv_i,
  input  logic                     run_i,
  input  logic                     cmd_valid_i,
  input  logic                     cmd_est_i,
  input  logic [$clog2(NCH)-1:0]   cmd_chan_i,
  output logic                     cmd_ready_o,
  output logic                     sw_valid_o,
  input  logic                     sw_ready_i,
  output logic [$clog2(NCH)-1:0]   sw_chan_o,
  output logic [SW_W-1:0]          sw_word_o,
  output logic [IMG_W-1:0]         img_o
);
  localparam int CW  = $clog2(NCH);
  localparam int LOW = IMG_W - 2*NCH;

  logic [NCH-1:0] active, err, pend, imgx, imge;
  logic [NCH-1:0] sel, bsel, kill, join_m, live;
  logic [NCH-1:0] act_n, err_n, pend_n, imgx_n, imge_n;
  logic           busy, run_q;
  logic [CW-1:0]  bchan;
  logic           cmd_ok, est_acc, sw_done, stop_edge;

  assign cmd_ready_o = !busy;
  assign cmd_ok      = cmd_valid_i && !busy && (32'(cmd_chan_i) < NCH);
  assign est_acc     = cmd_ok && cmd_est_i;
  assign sw_done     = busy && sw_ready_i;
  assign stop_edge   = run_q && !run_i;

  assign sw_valid_o = busy;
  assign sw_chan_o  = bchan;
  assign sw_word_o  = SW_W'(OK_CODE);

  assign sel    = NCH'(1) << cmd_chan_i;
  assign bsel   = NCH'(1) << bchan;
  assign kill   = cmd_ok ? sel : '0;
  assign join_m = sw_done ? bsel : '0;
  assign live   = (active | join_m) & ~kill;

  assign act_n  = (active & ~kill) | join_m;
  assign err_n  = ((err & ~err_rcv_i) | (err_det_i & live)) & ~kill & ~{NCH{stop_edge}};
  assign pend_n = (scan_i ? (xfer_i & live) : (pend | (xfer_i & live))) & ~kill;
  assign imgx_n = (scan_i ? pend : imgx) & ~kill;
  assign imge_n = (scan_i ? err : imge) & ~kill;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= '0;
      err    <= '0;
      pend   <= '0;
      imgx   <= '0;
      imge   <= '0;
      busy   <= 1'b0;
      bchan  <= '0;
      run_q  <= 1'b0;
    end else begin
      active <= act_n;
      err    <= err_n;
      pend   <= pend_n;
      imgx   <= imgx_n;
      imge   <= imge_n;
      run_q  <= run_i;
      if (est_acc) begin
        busy  <= 1'b1;
        bchan <= cmd_chan_i;
      end else if (sw_done) begin
        busy  <= 1'b0;
      end
    end
  end

  assign img_o[LOW-1:0] = '0;
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign img_o[LOW+2*c]   = imgx[c];
    assign img_o[LOW+2*c+1] = imge[c];

    p_inactive_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      !active[c] |-> !err[c] && !pend[c] && !img_o[LOW+2*c] && !img_o[LOW+2*c+1]);

    p_pulse_drop_r3: assert property (@(posedge clk) disable iff (rst)
      (scan_i && !pend[c]) |=> !img_o[LOW+2*c]);
  end

  p_no_rise_between_scans_r2: assert property (@(posedge clk) disable iff (rst)
    !scan_i |=> ((img_o & ~$past(img_o)) == '0));

  p_stop_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (run_q && !run_i) |=> (err == '0));

  p_word_held_r8: assert property (@(posedge clk) disable iff (rst)
    (sw_valid_o && !sw_ready_i) |=> (sw_valid_o && $stable(sw_chan_o) && !cmd_ready_o));

  p_word_first_r8: assert property (@(posedge clk) disable iff (rst)
    sw_valid_o |-> (!img_o[LOW+2*sw_chan_o] && !img_o[LOW+2*sw_chan_o+1] && !active[sw_chan_o]));

  p_join_clean_r9: assert property (@(posedge clk) disable iff (rst)
    (sw_valid_o && sw_ready_i && !err_det_i[sw_chan_o]) |=> (active[$past(sw_chan_o)] && !err[$past(sw_chan_o)]));
endmodule

// File: tb/sim_chan_status_img.sv
module sim_chan_status_img;
  localparam int TCK = 10;

  logic        clk = 0, rst = 1, scan_i = 0, run_i = 1;
  logic [31:0] xfer_i = 0, err_det_i = 0, err_rcv_i = 0;
  logic        cmd_valid_i = 0, cmd_est_i = 0, sw_ready_i = 0;
  logic [4:0]  cmd_chan_i = 0;
  logic        cmd_ready_o, sw_valid_o;
  logic [4:0]  sw_chan_o;
  logic [15:0] sw_word_o;
  logic [79:0] img_o;
  int checks = 0, fails = 0;
  bit done = 0;

  chan_status_img u0 (.*);

  always #(TCK/2) clk = ~clk;

  // vector fields {xfer, det, rcv, exp_x, exp_e} on channel 3
  localparam logic [4:0] VEC [8] = '{5'b00000, 5'b10010, 5'b00000, 5'b11011,
                                     5'b00001, 5'b00100, 5'b01101, 5'b10110};

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ev(input int ch, input bit x, input bit d, input bit r);
    @(negedge clk);
    xfer_i[ch] = x; err_det_i[ch] = d; err_rcv_i[ch] = r;
    @(negedge clk);
    xfer_i = 0; err_det_i = 0; err_rcv_i = 0;
  endtask

  task automatic scan();
    @(negedge clk); scan_i = 1;
    @(negedge clk); scan_i = 0;
  endtask

  task automatic cmd(input bit est, input int ch);
    @(negedge clk); cmd_valid_i = 1; cmd_est_i = est; cmd_chan_i = 5'(ch);
    @(negedge clk); cmd_valid_i = 0;
  endtask

  task automatic hs(input int ch, input bit x, input bit d);
    @(negedge clk); sw_ready_i = 1; xfer_i[ch] = x; err_det_i[ch] = d;
    @(negedge clk); sw_ready_i = 0; xfer_i = 0; err_det_i = 0;
  endtask

  function automatic logic [1:0] bits(input int ch);
    return {img_o[17+2*ch], img_o[16+2*ch]};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(img_o == 0 && !sw_valid_o && cmd_ready_o, "R10 reset state", img_o, 0);

    ev(5, 1, 1, 0); scan();
    chk(bits(5) == 2'b00, "R6 never-established channel ignores events", 80'(bits(5)), 0);

    cmd(1, 3);
    chk(sw_valid_o && sw_chan_o == 3 && sw_word_o == 16'h0001 && !cmd_ready_o,
        "R8 status word presented", {sw_valid_o, sw_chan_o, sw_word_o}, {1'b1, 5'd3, 16'h0001});
    ev(3, 1, 1, 0); scan();
    chk(bits(3) == 2'b00 && sw_valid_o, "R8 bits held while word pending", 80'(bits(3)), 0);
    hs(3, 0, 0);
    chk(!sw_valid_o && cmd_ready_o, "R8 handshake completes", 80'(sw_valid_o), 0);
    scan(); scan();
    chk(bits(3) == 2'b00, "R8 events during pending write ignored", 80'(bits(3)), 0);

    for (int i = 0; i < 8; i++) begin
      logic [1:0] prev;
      prev = bits(3);
      ev(3, VEC[i][4], VEC[i][3], VEC[i][2]);
      chk(bits(3) == prev, "R2 image holds between strobes", 80'(bits(3)), 80'(prev));
      scan();
      chk(bits(3) == {VEC[i][0], VEC[i][1]}, "R3 R4 R5 table step", 80'(bits(3)), 80'({VEC[i][0], VEC[i][1]}));
    end

    ev(3, 1, 0, 0); ev(3, 1, 0, 0); scan();
    chk(bits(3) == 2'b01, "R3 multiple events one pulse", 80'(bits(3)), 1);
    scan();
    chk(bits(3) == 2'b00, "R3 pulse lasts one scan", 80'(bits(3)), 0);

    @(negedge clk); scan_i = 1; xfer_i[3] = 1;
    @(negedge clk); scan_i = 0; xfer_i = 0;
    chk(bits(3) == 2'b00, "R3 strobe-cycle event not in this scan", 80'(bits(3)), 0);
    scan();
    chk(bits(3) == 2'b01, "R3 strobe-cycle event in next scan", 80'(bits(3)), 1);
    scan();

    cmd(1, 7); hs(7, 1, 1); scan();
    chk(img_o == ((80'd1 << 30) | (80'd1 << 31)), "R1 R9 layout and handshake-cycle events",
        img_o, (80'd1 << 30) | (80'd1 << 31));

    @(negedge clk); cmd_valid_i = 1; cmd_est_i = 0; cmd_chan_i = 7; err_det_i[7] = 1;
    @(negedge clk); cmd_valid_i = 0; err_det_i = 0;
    chk(bits(7) == 2'b00, "R6 abort clears bits next cycle", 80'(bits(7)), 0);
    ev(7, 1, 1, 0); scan();
    chk(bits(7) == 2'b00, "R6 aborted channel ignores events", 80'(bits(7)), 0);

    ev(3, 0, 1, 0); scan();
    chk(bits(3) == 2'b10, "R4 error set before stop", 80'(bits(3)), 2);
    @(negedge clk); run_i = 0; err_det_i[3] = 1;
    @(negedge clk); err_det_i = 0;
    chk(bits(3) == 2'b10, "R7 image waits for strobe", 80'(bits(3)), 2);
    scan();
    chk(bits(3) == 2'b00, "R7 stop clears error", 80'(bits(3)), 0);
    run_i = 1;

    ev(3, 1, 1, 0); scan();
    chk(bits(3) == 2'b11, "R10 state before reset", 80'(bits(3)), 3);
    @(negedge clk); rst = 1;
    @(negedge clk);
    chk(img_o == 0 && cmd_ready_o && !sw_valid_o, "R10 reset clears image", img_o, 0);
    rst = 0;
    ev(3, 1, 1, 0); scan();
    chk(bits(3) == 2'b00, "R10 channels inactive after reset", 80'(bits(3)), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule